// File: doc/BRIEF.md
# Display Controller Boot and Line-Drive Sequencer

This block brings a display system controller out of reset once its supply is good. It releases the resets in a fixed order. First it waits for the main reset input to go high. After a programmed delay it frees the deflection processor. After a second programmed delay it frees every other peripheral. The teletext processor takes an active-high copy of the peripheral reset.

Horizontal drive is blocked by an inhibit output, which also mutes the audio amplifiers. The inhibit stays high until the whole boot sequence has finished. It rises again whenever the serial control buses report a communication failure.

A separate path watches an active-low protection input. When that input stays low long enough, the block raises a standby request. The request holds until the supply-good signal drops.

Top module: `disp_boot_seq`

## Requirements
- R1: While `rst_n` is low, or `supply_ok` is low, the outputs are held as follows: `defl_rst_n`=0, `periph_rst_n`=0, `ttx_rst`=1, `hout_inhibit`=1, `audio_mute`=1 and `standby_req`=0.
- R2: With `supply_ok` already high, `defl_rst_n` rises on the (DEFL_GAP+1)-th rising clock edge after `main_rst_n` goes high. It never rises while `main_rst_n` is low.
- R3: `periph_rst_n` rises PERI_GAP rising edges after `defl_rst_n` rises. It is never high while `defl_rst_n` is low.
- R4: `ttx_rst` is always the inverse of `periph_rst_n`; it is active high.
- R5: With `bus_ok` high, `hout_inhibit` falls one rising edge after `periph_rst_n` rises. `hout_inhibit` is low only while both reset outputs are released.
- R6: `audio_mute` equals `hout_inhibit` in every cycle.
- R7: `bus_ok` low at a rising edge makes `hout_inhibit` high after that edge. When `bus_ok` returns high in the running state, `hout_inhibit` falls one edge later.
- R8: `supply_ok` low at a rising edge re-asserts both resets and the inhibit, and clears `standby_req`, after that edge. When `supply_ok` comes back with `main_rst_n` high, `defl_rst_n` rises DEFL_GAP+2 edges later.
- R9: `main_rst_n` low at a rising edge re-asserts both resets and the inhibit after that edge. The sequence then restarts from waiting for `main_rst_n`.
- R10: `prot_n` low on PROT_DEB consecutive rising edges sets `standby_req` after the last of them. A shorter low pulse leaves `standby_req` at 0.
- R11: Once set, `standby_req` stays high whatever `prot_n` does, for as long as `supply_ok` stays high.
- R12: When supply loss and debounce completion fall on the same edge, supply loss wins, and `standby_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| supply_ok | input | 1 | High while the supply rails are good |
| main_rst_n | input | 1 | Main reset input; low holds the sequence |
| bus_ok | input | 1 | High while communication on the serial control buses succeeds |
| prot_n | input | 1 | Protection input; low signals a fault |
| defl_rst_n | output | 1 | Deflection processor reset, active low |
| periph_rst_n | output | 1 | Reset for the remaining peripherals, active low |
| ttx_rst | output | 1 | Teletext processor reset, active high |
| hout_inhibit | output | 1 | Horizontal-output inhibit; high blocks line drive |
| audio_mute | output | 1 | Audio mute; follows the inhibit |
| standby_req | output | 1 | Latched standby request |

## Verification
Two kinds of event can land on the same clock edge.

The first pair is a bus failure and the end of the boot sequence. The bench holds `bus_ok` low across the edge on which `periph_rst_n` is released. It then expects the inhibit to stay high, with no falling edge of the inhibit reported until `bus_ok` returns.

The second pair is a supply loss and the final edge of the protection debounce. The bench lets `prot_n` stay low for one edge fewer than the debounce length, and then drops `supply_ok` on the completing edge. It expects `standby_req` to stay at 0 after that edge.

// File: rtl/disp_boot_pkg.sv
package disp_boot_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_WAIT_MAIN = 3'd1,
    ST_DEFL_WAIT = 3'd2,
    ST_PERI_WAIT = 3'd3,
    ST_RUN       = 3'd4
  } seq_state_e;

  // A gap of N cycles ends on the edge at which the running count reaches N-1.
  function automatic logic gap_reached(input int unsigned count, input int unsigned gap);
    return (count + 1) >= gap;
  endfunction

endpackage

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import disp_boot_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DEFL_GAP = 8,
  parameter int unsigned PERI_GAP = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic main_rst_n,
  output logic defl_rel,
  output logic peri_rel
);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Named internal events
  logic ev_defl_release;
  logic ev_peri_release;
  logic ev_abort;

  assign ev_abort        = !supply_ok || !main_rst_n;
  assign ev_defl_release = !ev_abort && (st_q == ST_DEFL_WAIT) &&
                           gap_reached(int'(cnt_q), DEFL_GAP);
  assign ev_peri_release = !ev_abort && (st_q == ST_PERI_WAIT) &&
                           gap_reached(int'(cnt_q), PERI_GAP);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!supply_ok) begin
      st_d  = ST_OFF;
      cnt_d = '0;
    end else if (!main_rst_n) begin
      st_d  = ST_WAIT_MAIN;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_OFF:       st_d = ST_WAIT_MAIN;
        ST_WAIT_MAIN: begin
          st_d  = ST_DEFL_WAIT;
          cnt_d = '0;
        end
        ST_DEFL_WAIT: begin
          if (ev_defl_release) begin
            st_d  = ST_PERI_WAIT;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PERI_WAIT: begin
          if (ev_peri_release) begin
            st_d  = ST_RUN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RUN:  st_d = ST_RUN;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign defl_rel = (st_q == ST_PERI_WAIT) || (st_q == ST_RUN);
  assign peri_rel = (st_q == ST_RUN);

  // R2: the deflection reset is freed only after the main reset input was high
  assert_defl_after_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(defl_rel) |-> $past(main_rst_n));

  // R3: the peripheral reset is freed only from a released deflection reset
  assert_peri_after_defl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(peri_rel) |-> $past(defl_rel));

  // R8: supply loss re-asserts both resets on the next edge
  assert_supply_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!defl_rel && !peri_rel));

  // R9: main reset low re-asserts both resets on the next edge
  assert_main_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !main_rst_n |=> (!defl_rel && !peri_rel));

  // R2/R3: release events are exclusive
  assert_release_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_defl_release, ev_peri_release}));

endmodule

// File: rtl/prot_filter.sv
module prot_filter
  import disp_boot_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PROT_DEB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic prot_n,
  output logic standby_req
);

  logic [CNT_W-1:0] low_cnt_q;
  logic             latch_q;
  logic             ev_trip;

  assign ev_trip = supply_ok && !latch_q && !prot_n &&
                   gap_reached(int'(low_cnt_q), PROT_DEB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      latch_q   <= 1'b0;
    end else if (!supply_ok) begin
      low_cnt_q <= '0;
      latch_q   <= 1'b0;
    end else if (!latch_q) begin
      if (ev_trip) begin
        latch_q <= 1'b1;
      end else if (!prot_n) begin
        low_cnt_q <= low_cnt_q + 1'b1;
      end else begin
        low_cnt_q <= '0;
      end
    end
  end

  assign standby_req = latch_q;

  // R10: a request only appears after the protection input was low
  assert_trip_needs_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby_req) |-> $past(!prot_n));

  // R11: the request holds while the supply stays good
  assert_latch_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_req && supply_ok) |=> standby_req);

  // R12: supply loss clears the request, even on a completing debounce edge
  assert_supply_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !standby_req);

endmodule

// File: rtl/inhibit_ctl.sv
module inhibit_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic main_rst_n,
  input  logic bus_ok,
  input  logic run,
  output logic hout_inhibit,
  output logic audio_mute
);

  logic inh_q;
  logic ev_drive_ok;

  // Drive may run only from the running state with healthy buses and inputs
  assign ev_drive_ok = run && bus_ok && supply_ok && main_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inh_q <= 1'b1;
    else        inh_q <= !ev_drive_ok;
  end

  assign hout_inhibit = inh_q;
  assign audio_mute   = inh_q;

  // R7: a bus failure re-asserts the inhibit on the next edge
  assert_bus_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ok |=> hout_inhibit);

  // R5: the inhibit can fall only when the sequence was already running
  assert_inhibit_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hout_inhibit) |-> $past(run));

endmodule

// File: rtl/disp_boot_seq.sv
module disp_boot_seq #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DEFL_GAP = 8,
  parameter int unsigned PERI_GAP = 6,
  parameter int unsigned PROT_DEB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic main_rst_n,
  input  logic bus_ok,
  input  logic prot_n,
  output logic defl_rst_n,
  output logic periph_rst_n,
  output logic ttx_rst,
  output logic hout_inhibit,
  output logic audio_mute,
  output logic standby_req
);

  logic defl_rel;
  logic peri_rel;

  boot_seq_fsm #(
    .CNT_W   (CNT_W),
    .DEFL_GAP(DEFL_GAP),
    .PERI_GAP(PERI_GAP)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .main_rst_n(main_rst_n),
    .defl_rel  (defl_rel),
    .peri_rel  (peri_rel)
  );

  inhibit_ctl u_inh (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .main_rst_n  (main_rst_n),
    .bus_ok      (bus_ok),
    .run         (peri_rel),
    .hout_inhibit(hout_inhibit),
    .audio_mute  (audio_mute)
  );

  prot_filter #(
    .CNT_W   (CNT_W),
    .PROT_DEB(PROT_DEB)
  ) u_prot (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .prot_n     (prot_n),
    .standby_req(standby_req)
  );

  assign defl_rst_n   = defl_rel;
  assign periph_rst_n = peri_rel;
  assign ttx_rst      = ~peri_rel;

  // R5: line drive is unblocked only with both resets released
  assert_inhibit_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hout_inhibit |-> (defl_rst_n && periph_rst_n));

  // R3: the peripheral reset never leads the deflection reset
  assert_reset_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_n |-> defl_rst_n);

  // R8: supply loss raises the inhibit on the next edge
  assert_supply_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (hout_inhibit && audio_mute));

endmodule

// File: tb/disp_boot_seq_tb.sv
module disp_boot_seq_tb;

  localparam int unsigned DG = 8;
  localparam int unsigned PG = 6;
  localparam int unsigned PD = 4;

  logic clk = 1'b0;
  logic rst_n, supply_ok, main_rst_n, bus_ok, prot_n;
  logic defl_rst_n, periph_rst_n, ttx_rst, hout_inhibit, audio_mute, standby_req;

  always #10 clk = ~clk;

  disp_boot_seq #(.CNT_W(16), .DEFL_GAP(DG), .PERI_GAP(PG), .PROT_DEB(PD)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .main_rst_n(main_rst_n),
    .bus_ok(bus_ok), .prot_n(prot_n), .defl_rst_n(defl_rst_n),
    .periph_rst_n(periph_rst_n), .ttx_rst(ttx_rst), .hout_inhibit(hout_inhibit),
    .audio_mute(audio_mute), .standby_req(standby_req)
  );

  typedef struct {
    string tag;
    int    gap;
  } exp_item_t;

  exp_item_t exp_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int t_main   = 0;
  int t_defl   = 0;
  int t_peri   = 0;
  int t_bus    = 0;
  bit done     = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string tag, input int gap);
    exp_item_t it;
    it.tag = tag;
    it.gap = gap;
    exp_q.push_back(it);
  endtask

  task automatic expect_pop(input string what, input int gap);
    exp_item_t it;
    if (exp_q.size() == 0) begin
      check(1'b0, {"unexpected ", what}, gap, -1);
    end else begin
      it = exp_q.pop_front();
      check(it.gap == gap, it.tag, gap, it.gap);
    end
  endtask

  // Monitor: measures the spacing of output edges, compares with the queue
  logic p_defl = 1'b0, p_peri = 1'b0, p_inh = 1'b1;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (defl_rst_n && !p_defl) begin
        t_defl = cyc;
        expect_pop("deflection release", cyc - t_main);
      end
      if (periph_rst_n && !p_peri) begin
        t_peri = cyc;
        expect_pop("peripheral release", cyc - t_defl);
      end
      if (!hout_inhibit && p_inh) begin
        expect_pop("inhibit release", cyc - ((t_peri > t_bus) ? t_peri : t_bus));
      end
    end
    p_defl = defl_rst_n;
    p_peri = periph_rst_n;
    p_inh  = hout_inhibit;
  end

  task automatic check_held(input string req);
    check(defl_rst_n == 1'b0,   req, defl_rst_n,   0);
    check(periph_rst_n == 1'b0, req, periph_rst_n, 0);
    check(ttx_rst == 1'b1,      req, ttx_rst,      1);
    check(hout_inhibit == 1'b1, req, hout_inhibit, 1);
    check(audio_mute == 1'b1,   req, audio_mute,   1);
  endtask

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; main_rst_n = 1'b0; bus_ok = 1'b1; prot_n = 1'b1;
    tick(3);
    // R1: reset state
    check_held("R1 reset");
    check(standby_req == 1'b0, "R1 reset standby", standby_req, 0);
    rst_n = 1'b1;
    tick(5);
    check_held("R1 supply low");

    // R2: nothing is released while the main reset is held
    supply_ok = 1'b1;
    tick(20);
    check(defl_rst_n == 1'b0, "R2 held by main", defl_rst_n, 0);

    // Boot: R2, R3, R5
    push("R2 deflection gap", DG + 1);
    push("R3 peripheral gap", PG);
    push("R5 inhibit gap", 1);
    t_main = cyc; main_rst_n = 1'b1;
    tick(DG + PG + 6);
    check(exp_q.size() == 0, "R2 R3 R5 queue drained", exp_q.size(), 0);
    check(ttx_rst == 1'b0, "R4 teletext released", ttx_rst, 0);
    check(audio_mute == 1'b0, "R6 mute follows inhibit", audio_mute, 0);

    // R7: bus loss and recovery
    bus_ok = 1'b0;
    tick(1);
    check(hout_inhibit == 1'b1, "R7 bus loss inhibit", hout_inhibit, 1);
    check(audio_mute == 1'b1, "R6 mute on bus loss", audio_mute, 1);
    check(periph_rst_n == 1'b1, "R7 resets kept", periph_rst_n, 1);
    push("R7 bus recovery gap", 1);
    t_bus = cyc; bus_ok = 1'b1;
    tick(3);
    check(exp_q.size() == 0, "R7 recovery seen", exp_q.size(), 0);

    // R9: main reset drop restarts the sequence
    main_rst_n = 1'b0;
    tick(1);
    check_held("R9 main drop");
    tick(3);

    // Collision: bus failed across the peripheral release edge (R7)
    bus_ok = 1'b0;
    push("R2 deflection gap again", DG + 1);
    push("R3 peripheral gap again", PG);
    t_main = cyc; main_rst_n = 1'b1;
    tick(DG + PG + 6);
    check(periph_rst_n == 1'b1, "R3 released under bus loss", periph_rst_n, 1);
    check(hout_inhibit == 1'b1, "R7 inhibit held at release", hout_inhibit, 1);
    push("R7 late bus recovery gap", 1);
    t_bus = cyc; bus_ok = 1'b1;
    tick(3);
    check(exp_q.size() == 0, "R7 late recovery seen", exp_q.size(), 0);

    // R10: short pulse ignored, full pulse trips
    prot_n = 1'b0;
    tick(PD - 1);
    prot_n = 1'b1;
    tick(3);
    check(standby_req == 1'b0, "R10 short pulse", standby_req, 0);
    prot_n = 1'b0;
    tick(PD - 1);
    check(standby_req == 1'b0, "R10 before last edge", standby_req, 0);
    tick(1);
    check(standby_req == 1'b1, "R10 trip", standby_req, 1);
    prot_n = 1'b1;
    tick(10);
    check(standby_req == 1'b1, "R11 latched", standby_req, 1);

    // R8: supply loss clears everything, then restarts with main high
    supply_ok = 1'b0;
    tick(1);
    check_held("R8 supply loss");
    check(standby_req == 1'b0, "R8 standby cleared", standby_req, 0);
    tick(3);
    push("R8 restart deflection gap", DG + 2);
    push("R8 restart peripheral gap", PG);
    push("R8 restart inhibit gap", 1);
    t_main = cyc; supply_ok = 1'b1;
    tick(DG + PG + 8);
    check(exp_q.size() == 0, "R8 restart complete", exp_q.size(), 0);

    // R12: supply loss on the debounce completing edge
    prot_n = 1'b0;
    tick(PD - 1);
    supply_ok = 1'b0;
    tick(1);
    check(standby_req == 1'b0, "R12 supply wins", standby_req, 0);
    tick(5);
    check(standby_req == 1'b0, "R12 held while off", standby_req, 0);
    prot_n = 1'b1;
    tick(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule